// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the top-level operating state of a DRAM protocol controller. Software posts a state-change command (initialise, configure, go, sleep, wake). The sequencer accepts the command only where it is legal. It moves into a request state and stays there until the memory-side interface acknowledges the step. Only then does it settle in the new stable state. The current state is reported as a 3-bit code.

Low power can be entered in two ways. Software can issue a sleep command, or the hardware can raise a low-power request while a hardware-low-power enable is set. The sequencer records which source caused the entry and reports it as a 3-bit trigger code. A low-power state entered by hardware is left by hardware: it starts the exit on its own when the hardware request drops. Software can therefore treat that state as usable and need not issue a wake command. A low-power state entered by software stays put until a wake command arrives.

Top module: `dram_op_state`

## Requirements
- R1: Reset (rst_n low, asynchronous) puts the state code at 0 (INIT_MEM) and the trigger code at 0.
- R2: The state codes are INIT_MEM=0, CONFIG=1, CONFIG_REQ=2, ACCESS=3, ACCESS_REQ=4, LOW_POWER=5, LP_ENTRY_REQ=6 and LP_EXIT_REQ=7. The command codes are INIT=0, CFG=1, GO=2, SLEEP=3 and WAKEUP=4. A CFG command in INIT_MEM or ACCESS moves the state to CONFIG_REQ at the next clock edge. A phase_ack in CONFIG_REQ then moves it to CONFIG.
- R3: A GO command in CONFIG moves the state to ACCESS_REQ. A phase_ack there moves it to ACCESS.
- R4: A SLEEP command in ACCESS moves the state to LP_ENTRY_REQ and sets the trigger code to 2 (software). An lp_in_ack there moves the state to LOW_POWER, and the trigger code stays at 2.
- R5: In ACCESS with no accepted command, hw_lp_req high together with hw_lp_en high moves the state to LP_ENTRY_REQ with trigger code 1 (hardware). With hw_lp_en low the request is ignored.
- R6: A WAKEUP command in LOW_POWER moves the state to LP_EXIT_REQ. An lp_out_ack there moves it to ACCESS and clears the trigger code to 0.
- R7: In LOW_POWER with trigger code 1, hw_lp_req going low moves the state to LP_EXIT_REQ without any command. With trigger code 2, hw_lp_req has no effect in LOW_POWER.
- R8: Each request state holds until its own acknowledge arrives: phase_ack for CONFIG_REQ and ACCESS_REQ, lp_in_ack for LP_ENTRY_REQ, lp_out_ack for LP_EXIT_REQ. Other acknowledges and all commands are ignored in a request state.
- R9: A command that is not legal in the current stable state is ignored. This includes INIT and the codes 5 to 7 in every state.
- R10: When a legal command and an enabled hardware request arrive in ACCESS in the same cycle, the command wins, and the trigger code follows the command.
- R11: The trigger code is nonzero only in LOW_POWER, LP_ENTRY_REQ and LP_EXIT_REQ. It holds its value from entry until the exit acknowledge.
- R12: stat_word carries the state code in bits 2:0 and the trigger code in bits 6:4. Bits 3 and 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is posted this cycle |
| cmd_code | input | 3 | State-change command code |
| phase_ack | input | 1 | Memory side has finished a config/access step |
| lp_in_ack | input | 1 | Memory side has entered low power |
| lp_out_ack | input | 1 | Memory side has left low power |
| hw_lp_en | input | 1 | Allows hardware-initiated low power |
| hw_lp_req | input | 1 | Hardware low-power request (level) |
| stat_code | output | 3 | Current state code |
| lp_trig | output | 3 | Low-power trigger code (0 none, 1 hardware, 2 software) |
| stat_word | output | 8 | Packed status: state in 2:0, trigger in 6:4 |

## Verification
The bench sweeps every command code, legal and illegal, from each of the four stable states. This separates accepted transitions from ignored ones and catches any wrong target state. Each request state is then hit with the acknowledges that belong to other steps and with every command. This shows the sequencer waits only for its own acknowledge. Two low-power round trips, one entered by software and one by hardware, show the trigger code at every step. They also show that only the hardware-entered state leaves by itself when the request drops. A final case raises an enabled hardware request in the same cycle as a command, to confirm that the command wins.

// File: rtl/dram_op_state_pkg.sv
package dram_op_state_pkg;

  localparam int ST_W   = 3;
  localparam int CMD_W  = 3;
  localparam int TRIG_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_INIT_MEM   = 3'd0,
    ST_CONFIG     = 3'd1,
    ST_CFG_REQ    = 3'd2,
    ST_ACCESS     = 3'd3,
    ST_ACC_REQ    = 3'd4,
    ST_LOW_POWER  = 3'd5,
    ST_LP_IN_REQ  = 3'd6,
    ST_LP_OUT_REQ = 3'd7
  } dos_state_e;

  localparam logic [CMD_W-1:0] CMD_INIT  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_CFG   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GO    = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKE  = 3'd4;

  localparam logic [TRIG_W-1:0] TRIG_NONE = 3'd0;
  localparam logic [TRIG_W-1:0] TRIG_HW   = 3'd1;
  localparam logic [TRIG_W-1:0] TRIG_SW   = 3'd2;

  // Destination of a command from a stable state; returns the state itself
  // when the command is not legal there.
  function automatic dos_state_e f_cmd_dest(dos_state_e st, logic [CMD_W-1:0] cmd);
    dos_state_e d;
    d = st;
    case (st)
      ST_INIT_MEM:  if (cmd == CMD_CFG) d = ST_CFG_REQ;
      ST_CONFIG:    if (cmd == CMD_GO) d = ST_ACC_REQ;
      ST_ACCESS: begin
        if (cmd == CMD_CFG)        d = ST_CFG_REQ;
        else if (cmd == CMD_SLEEP) d = ST_LP_IN_REQ;
      end
      ST_LOW_POWER: if (cmd == CMD_WAKE) d = ST_LP_OUT_REQ;
      default: d = st;
    endcase
    return d;
  endfunction

  // Stable state reached when a request state receives its acknowledge.
  function automatic dos_state_e f_ack_dest(dos_state_e st);
    dos_state_e d;
    case (st)
      ST_CFG_REQ:    d = ST_CONFIG;
      ST_ACC_REQ:    d = ST_ACCESS;
      ST_LP_IN_REQ:  d = ST_LOW_POWER;
      ST_LP_OUT_REQ: d = ST_ACCESS;
      default:       d = st;
    endcase
    return d;
  endfunction

  // Packs state and trigger into the status word layout.
  function automatic logic [7:0] f_pack_stat(logic [ST_W-1:0] st, logic [TRIG_W-1:0] tr);
    return {1'b0, tr, 1'b0, st};
  endfunction

endpackage

// File: rtl/dos_cmd_filter.sv
module dos_cmd_filter
  import dram_op_state_pkg::*;
(
  input  dos_state_e       st,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             cmd_take,
  output dos_state_e       cmd_dest
);
  dos_state_e dest_raw;

  always_comb begin
    dest_raw = f_cmd_dest(st, cmd_code);
    cmd_take = cmd_valid && (dest_raw != st);
    cmd_dest = cmd_take ? dest_raw : st;
  end
endmodule

// File: rtl/dos_ack_filter.sv
module dos_ack_filter
  import dram_op_state_pkg::*;
(
  input  dos_state_e st,
  input  logic       phase_ack,
  input  logic       lp_in_ack,
  input  logic       lp_out_ack,
  output logic       ack_hit,
  output dos_state_e ack_dest
);
  always_comb begin
    case (st)
      ST_CFG_REQ, ST_ACC_REQ: ack_hit = phase_ack;
      ST_LP_IN_REQ:           ack_hit = lp_in_ack;
      ST_LP_OUT_REQ:          ack_hit = lp_out_ack;
      default:                ack_hit = 1'b0;
    endcase
    ack_dest = f_ack_dest(st);
  end
endmodule

// File: rtl/dos_trig_track.sv
module dos_trig_track
  import dram_op_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_enter,
  input  logic              enter_by_hw,
  input  logic              lp_leave,
  output logic [TRIG_W-1:0] trig_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trig_q <= TRIG_NONE;
    else if (lp_enter) trig_q <= enter_by_hw ? TRIG_HW : TRIG_SW;
    else if (lp_leave) trig_q <= TRIG_NONE;
  end
endmodule

// File: rtl/dram_op_state.sv
module dram_op_state
  import dram_op_state_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_code,
  input  logic        phase_ack,
  input  logic        lp_in_ack,
  input  logic        lp_out_ack,
  input  logic        hw_lp_en,
  input  logic        hw_lp_req,
  output logic [2:0]  stat_code,
  output logic [2:0]  lp_trig,
  output logic [7:0]  stat_word
);
  dos_state_e        st_q, st_nxt;
  dos_state_e        cmd_dest, ack_dest;
  logic              cmd_take, ack_hit;
  logic              hw_entry, hw_exit;
  logic              lp_enter, lp_leave;
  logic [TRIG_W-1:0] trig_q;

  dos_cmd_filter u_cmd (
    .st        (st_q),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_take  (cmd_take),
    .cmd_dest  (cmd_dest)
  );

  dos_ack_filter u_ack (
    .st         (st_q),
    .phase_ack  (phase_ack),
    .lp_in_ack  (lp_in_ack),
    .lp_out_ack (lp_out_ack),
    .ack_hit    (ack_hit),
    .ack_dest   (ack_dest)
  );

  // Hardware-side events; software commands take precedence.
  assign hw_entry = (st_q == ST_ACCESS) && hw_lp_en && hw_lp_req && !cmd_take;
  assign hw_exit  = (st_q == ST_LOW_POWER) && (trig_q == TRIG_HW) && !hw_lp_req && !cmd_take;

  always_comb begin
    st_nxt = st_q;
    if (ack_hit)       st_nxt = ack_dest;
    else if (cmd_take) st_nxt = cmd_dest;
    else if (hw_entry) st_nxt = ST_LP_IN_REQ;
    else if (hw_exit)  st_nxt = ST_LP_OUT_REQ;
  end

  assign lp_enter = (st_q == ST_ACCESS) && (st_nxt == ST_LP_IN_REQ);
  assign lp_leave = (st_q == ST_LP_OUT_REQ) && ack_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_INIT_MEM;
    else        st_q <= st_nxt;
  end

  dos_trig_track u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_enter    (lp_enter),
    .enter_by_hw (hw_entry),
    .lp_leave    (lp_leave),
    .trig_q      (trig_q)
  );

  assign stat_code = st_q;
  assign lp_trig   = trig_q;
  assign stat_word = f_pack_stat(st_q, trig_q);
endmodule

// File: rtl/dram_op_state_chk.sv
module dram_op_state_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       phase_ack,
  input logic       lp_in_ack,
  input logic       lp_out_ack,
  input logic       hw_lp_en,
  input logic       hw_lp_req,
  input logic [2:0] stat_code,
  input logic [2:0] lp_trig
);
  assert_cfg_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd2 && !phase_ack) |=> (stat_code == 3'd2));
  assert_acc_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd4 && !phase_ack) |=> (stat_code == 3'd4));
  assert_lp_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd6 && !lp_in_ack) |=> (stat_code == 3'd6));
  assert_lp_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd7 && !lp_out_ack) |=> (stat_code == 3'd7));
  assert_init_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd0 && !(cmd_valid && cmd_code == 3'd1)) |=> (stat_code == 3'd0));
  assert_hw_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd3 && !hw_lp_en && !cmd_valid) |=> (stat_code == 3'd3));
  assert_trig_scope_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_trig != 3'd0) |-> (stat_code >= 3'd5));
  assert_lp_entry_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd5 && $past(stat_code) != 3'd5) |-> ($past(stat_code) == 3'd6));
  assert_config_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd1 && $past(stat_code) != 3'd1) |-> ($past(stat_code) == 3'd2));
  assert_sw_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd5 && lp_trig == 3'd2 && !(cmd_valid && cmd_code == 3'd4))
    |=> (stat_code == 3'd5));
  assert_hw_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd5 && lp_trig == 3'd1 && !hw_lp_req && !cmd_valid)
    |=> (stat_code == 3'd7));
  assert_cmd_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 3'd3 && cmd_valid && cmd_code == 3'd1) |=> (stat_code == 3'd2));
endmodule

bind dram_op_state dram_op_state_chk u_dram_op_state_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .phase_ack  (phase_ack),
  .lp_in_ack  (lp_in_ack),
  .lp_out_ack (lp_out_ack),
  .hw_lp_en   (hw_lp_en),
  .hw_lp_req  (hw_lp_req),
  .stat_code  (stat_code),
  .lp_trig    (lp_trig)
);

// File: tb/dram_op_state_bench.sv
module dram_op_state_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       phase_ack = 1'b0, lp_in_ack = 1'b0, lp_out_ack = 1'b0;
  logic       hw_lp_en = 1'b0, hw_lp_req = 1'b0;
  logic [2:0] stat_code, lp_trig;
  logic [7:0] stat_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dram_op_state u_dram_op_state (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .phase_ack(phase_ack), .lp_in_ack(lp_in_ack), .lp_out_ack(lp_out_ack),
    .hw_lp_en(hw_lp_en), .hw_lp_req(hw_lp_req),
    .stat_code(stat_code), .lp_trig(lp_trig), .stat_word(stat_word)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected destination of a command, written from the requirement text.
  function automatic logic [2:0] want_after_cmd(logic [2:0] s, logic [2:0] c);
    if (c == 3'd1 && (s == 3'd0 || s == 3'd3)) return 3'd2;
    if (c == 3'd2 && s == 3'd1) return 3'd4;
    if (c == 3'd3 && s == 3'd3) return 3'd6;
    if (c == 3'd4 && s == 3'd5) return 3'd7;
    return s;
  endfunction

  // Apply one cycle of command/ack stimulus; returns at the next falling edge.
  task automatic step(input logic cv, input logic [2:0] c, input logic pa,
                      input logic li, input logic lo);
    cmd_valid = cv; cmd_code = c; phase_ack = pa; lp_in_ack = li; lp_out_ack = lo;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0; phase_ack = 1'b0; lp_in_ack = 1'b0; lp_out_ack = 1'b0;
  endtask

  task automatic do_reset();
    hw_lp_en = 1'b0; hw_lp_req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Reach a stable state (0,1,3,5) from reset through the legal path.
  task automatic goto(input logic [2:0] s);
    do_reset();
    if (s == 3'd0) return;
    step(1, 3'd1, 0, 0, 0); step(0, 0, 1, 0, 0);
    if (s == 3'd1) return;
    step(1, 3'd2, 0, 0, 0); step(0, 0, 1, 0, 0);
    if (s == 3'd3) return;
    step(1, 3'd3, 0, 0, 0); step(0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tg;
    logic [2:0] exp_s;
    logic [2:0] base;
    logic [2:0] rq;
    logic [2:0] dst;
    int right;

    // R1: reset state
    @(negedge clk);
    check("R1 state in reset", {5'd0, stat_code}, 8'h00);
    do_reset();
    check("R1 state after reset", {5'd0, stat_code}, 8'h00);
    check("R1 trigger after reset", {5'd0, lp_trig}, 8'h00);
    check("R12 word after reset", stat_word, 8'h00);

    // Sweep every command code from every stable state (R2 R3 R4 R6 R9)
    for (int k = 0; k < 4; k++) begin
      base = (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : (k == 2) ? 3'd3 : 3'd5;
      for (int c = 0; c < 8; c++) begin
        goto(base);
        step(1, 3'(c), 0, 0, 0);
        exp_s = want_after_cmd(base, 3'(c));
        if (exp_s == base) tg = "R9 illegal command ignored";
        else if (c == 1) tg = "R2 CFG accepted";
        else if (c == 2) tg = "R3 GO accepted";
        else if (c == 3) tg = "R4 SLEEP accepted";
        else tg = "R6 WAKEUP accepted";
        check(tg, {5'd0, stat_code}, {5'd0, exp_s});
      end
    end

    // Request states: wait for own ack only (R8), then land (R2 R3 R4 R6)
    for (int r = 0; r < 4; r++) begin
      base  = (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : (r == 2) ? 3'd3 : 3'd5;
      rq    = (r == 0) ? 3'd2 : (r == 1) ? 3'd4 : (r == 2) ? 3'd6 : 3'd7;
      dst   = (r == 0) ? 3'd1 : (r == 1) ? 3'd3 : (r == 2) ? 3'd5 : 3'd3;
      right = (r < 2) ? 0 : (r == 2) ? 1 : 2;
      goto(base);
      step(1, want_after_cmd(base, 3'd0) == base ?
           ((r == 0) ? 3'd1 : (r == 1) ? 3'd2 : (r == 2) ? 3'd3 : 3'd4) : 3'd0, 0, 0, 0);
      check("R8 entered request state", {5'd0, stat_code}, {5'd0, rq});
      for (int a = 0; a < 3; a++) begin
        if (a != right) begin
          step(0, 0, a == 0, a == 1, a == 2);
          check("R8 foreign ack ignored", {5'd0, stat_code}, {5'd0, rq});
        end
      end
      for (int c = 0; c < 8; c++) begin
        step(1, 3'(c), 0, 0, 0);
        check("R8 command ignored in request", {5'd0, stat_code}, {5'd0, rq});
      end
      step(0, 0, right == 0, right == 1, right == 2);
      tg = (r == 0) ? "R2 CONFIG reached" : (r == 1) ? "R3 ACCESS reached" :
           (r == 2) ? "R4 LOW_POWER reached" : "R6 ACCESS after wake";
      check(tg, {5'd0, stat_code}, {5'd0, dst});
    end

    // Software low-power round trip: trigger code 2
    goto(3'd3);
    step(1, 3'd3, 0, 0, 0);
    check("R4 trigger software in entry", {5'd0, lp_trig}, 8'h02);
    step(0, 0, 0, 1, 0);
    check("R12 word software low power", stat_word, 8'h25);
    hw_lp_req = 1'b1; step(0, 0, 0, 0, 0);
    hw_lp_req = 1'b0; step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    check("R7 software low power ignores hw request", {5'd0, stat_code}, 8'h05);
    step(1, 3'd4, 0, 0, 0);
    check("R11 trigger held in exit request", {5'd0, lp_trig}, 8'h02);
    step(0, 0, 0, 0, 1);
    check("R6 trigger cleared on exit", {5'd0, lp_trig}, 8'h00);
    check("R12 word in access", stat_word, 8'h03);

    // Hardware low power: gated by enable, self-exit on request drop
    goto(3'd3);
    hw_lp_req = 1'b1;
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    check("R5 disabled hw request ignored", {5'd0, stat_code}, 8'h03);
    check("R5 no trigger when disabled", {5'd0, lp_trig}, 8'h00);
    hw_lp_en = 1'b1;
    step(0, 0, 0, 0, 0);
    check("R5 hw entry request", {5'd0, stat_code}, 8'h06);
    check("R5 trigger hardware", {5'd0, lp_trig}, 8'h01);
    step(0, 0, 0, 1, 0);
    check("R12 word hardware low power", stat_word, 8'h15);
    step(0, 0, 0, 0, 0);
    check("R7 holds while hw request high", {5'd0, stat_code}, 8'h05);
    hw_lp_req = 1'b0;
    step(0, 0, 0, 0, 0);
    check("R7 hw exit without command", {5'd0, stat_code}, 8'h07);
    check("R11 trigger held in hw exit", {5'd0, lp_trig}, 8'h01);
    step(0, 0, 0, 0, 1);
    check("R6 access after hw exit", stat_word, 8'h03);

    // Command beats hardware request in the same cycle
    goto(3'd3);
    hw_lp_en = 1'b1; hw_lp_req = 1'b1;
    step(1, 3'd1, 0, 0, 0);
    check("R10 CFG wins over hw request", {5'd0, stat_code}, 8'h02);
    check("R10 no trigger on CFG", {5'd0, lp_trig}, 8'h00);
    goto(3'd3);
    hw_lp_en = 1'b1; hw_lp_req = 1'b1;
    step(1, 3'd3, 0, 0, 0);
    check("R10 SLEEP with hw request gives software trigger", {5'd0, lp_trig}, 8'h02);
    hw_lp_req = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule